// File: doc/BRIEF.md
# Pipelined Floating-Point Significand Divider

This block divides two floating-point operands that have already been unpacked into a sign, an unbiased two's-complement exponent and a normalised significand whose most significant bit is set. Each significand stands for a fraction in [0.5, 1), so the quotient of the two always lies in (0.5, 2). The block works out the result sign and a provisional exponent in its first stage. It then produces the quotient with a chain of radix-2 restoring-division steps. A last stage packs the quotient into a result mantissa plus a mantissa-LSB copy and guard, round and sticky bits. A later rounding and post-normalisation unit consumes these outputs.

The sign, the exponent and a special-result bypass flag travel along a side channel next to the significand datapath. Each calculate stage resolves `BITS_PER` quotient bits, and the number of such stages is derived from the quotient width. Every stage is a register slice with a valid/ready handshake, so back-pressure at the output stalls the whole chain without losing or duplicating a result.

Top module: `fdiv_sig_pipe`

## Requirements
- R1: With QW = 2·SIG_W+2, the quotient Q is the QW-bit integer floor(sigA·2^(QW-1) / sigB). `out_mant` equals Q[QW-1:SIG_W+2], so for SIG_W=8 it is Q[17:10] with Q = floor(sigA·2^17 / sigB).
- R2: `out_lsb` equals Q[SIG_W+2], `out_guard` equals Q[SIG_W+1] and `out_round` equals Q[SIG_W].
- R3: `out_sticky` is 1 exactly when Q[SIG_W-1:0] is non-zero or the remainder sigA·2^(QW-1) mod sigB is non-zero.
- R4: `out_exp` is the two's-complement value exp_a − exp_b + 1, carried in EXP_W+2 bits so that it never wraps.
- R5: `out_sgn` is sgn_a XOR sgn_b.
- R6: When both significands have their MSB set and bypass is clear, the top two bits of `out_mant` are never both 0.
- R7: `out_bypass` repeats `in_bypass`. While it is 1, `out_mant`, `out_lsb`, `out_guard`, `out_round` and `out_sticky` are all 0, and sign and exponent still follow R4 and R5.
- R8: A transfer happens on a clock edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, every output holds its value on the next cycle.
- R9: Results leave in the order their operands were accepted, with none lost or duplicated.
- R10: With `out_ready` held high, a result appears NUM_CALC+2 cycles after its operands are accepted (8 with the defaults), and `in_ready` stays high, so one operation is accepted every cycle.
- R11: During and right after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| in_sgn_a | input | 1 | Dividend sign |
| in_exp_a | input | EXP_W | Dividend unbiased exponent, two's complement |
| in_sig_a | input | SIG_W | Dividend significand, MSB set |
| in_sgn_b | input | 1 | Divisor sign |
| in_exp_b | input | EXP_W | Divisor unbiased exponent, two's complement |
| in_sig_b | input | SIG_W | Divisor significand, MSB set |
| in_bypass | input | 1 | Special result already decided upstream |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_sgn | output | 1 | Result sign |
| out_exp | output | EXP_W+2 | Provisional result exponent |
| out_mant | output | SIG_W | Result mantissa before rounding |
| out_lsb | output | 1 | Copy of mantissa LSB for ties-to-even |
| out_guard | output | 1 | First bit below the mantissa |
| out_round | output | 1 | Second bit below the mantissa |
| out_sticky | output | 1 | OR of all lower quotient bits and the remainder |
| out_bypass | output | 1 | Bypass flag passed through |

## Verification
The hardest case to reach from the ports is a full pipeline frozen by back-pressure while operands of very different shapes are in flight. Some of those operands have an all-ones significand divided by an MSB-only one, which gives the largest quotient. Others are the reverse, which gives the smallest quotient, and some are exact divisions where only the remainder could set sticky. The stimulus first sends these extremes and the exponent limits, then runs a long random stream in which `in_valid` and `out_ready` toggle on their own. Each held result is compared cycle by cycle against its earlier value, and every accepted result against a reference integer division kept in a queue in the bench.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int DEF_SIG_W    = 8;
    localparam int DEF_EXP_W    = 10;
    localparam int DEF_BITS_PER = 3;

    // side-channel flags that ride beside the significand datapath
    typedef struct packed {
        logic sgn;
        logic byp;
    } fdiv_flag_t;

    function automatic int quo_width(input int sig_w);
        return 2 * sig_w + 2;
    endfunction

endpackage

// File: rtl/fdiv_setup.sv
module fdiv_setup
    import fdiv_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int EXP_W = DEF_EXP_W,
    parameter int QW    = quo_width(SIG_W),
    parameter int RX_W  = EXP_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic             a_sgn,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sgn,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic             byp,
    output logic             dn_valid,
    input  logic             dn_ready,
    output fdiv_flag_t       dn_flag,
    output logic [RX_W-1:0]  dn_exp,
    output logic [SIG_W:0]   dn_rem,
    output logic [SIG_W-1:0] dn_dvs,
    output logic [QW-1:0]    dn_quo
);

    typedef struct packed {
        logic             vld;
        fdiv_flag_t       flg;
        logic [RX_W-1:0]  ex;
        logic [SIG_W:0]   rem;
        logic [SIG_W-1:0] dvs;
        logic [QW-1:0]    quo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        up_ready = !st_q.vld || dn_ready;
        if (up_ready) begin
            st_d.vld = up_valid;
            if (up_valid) begin
                st_d.flg.sgn = a_sgn ^ b_sgn;
                st_d.flg.byp = byp;
                st_d.ex      = {{2{a_exp[EXP_W-1]}}, a_exp}
                             - {{2{b_exp[EXP_W-1]}}, b_exp}
                             + RX_W'(1);
                st_d.rem     = {1'b0, a_sig};
                st_d.dvs     = b_sig;
                st_d.quo     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dn_valid = st_q.vld;
    assign dn_flag  = st_q.flg;
    assign dn_exp   = st_q.ex;
    assign dn_rem   = st_q.rem;
    assign dn_dvs   = st_q.dvs;
    assign dn_quo   = st_q.quo;

    AST_SIG_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_ready |-> a_sig[SIG_W-1] && b_sig[SIG_W-1]); // R6

    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_exp) && $stable(dn_rem)); // R8

endmodule

// File: rtl/fdiv_calc.sv
module fdiv_calc
    import fdiv_pkg::*;
#(
    parameter int SIG_W    = DEF_SIG_W,
    parameter int RX_W     = DEF_EXP_W + 2,
    parameter int QW       = quo_width(SIG_W),
    parameter int BITS_PER = DEF_BITS_PER,
    parameter int ABS_BASE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    output logic             up_ready,
    input  fdiv_flag_t       up_flag,
    input  logic [RX_W-1:0]  up_exp,
    input  logic [SIG_W:0]   up_rem,
    input  logic [SIG_W-1:0] up_dvs,
    input  logic [QW-1:0]    up_quo,
    output logic             dn_valid,
    input  logic             dn_ready,
    output fdiv_flag_t       dn_flag,
    output logic [RX_W-1:0]  dn_exp,
    output logic [SIG_W:0]   dn_rem,
    output logic [SIG_W-1:0] dn_dvs,
    output logic [QW-1:0]    dn_quo
);

    // quotient bits not yet resolved after this stage
    localparam logic [QW-1:0] PEND_MASK = {QW{1'b1}} >> (ABS_BASE + BITS_PER);

    typedef struct packed {
        logic             vld;
        fdiv_flag_t       flg;
        logic [RX_W-1:0]  ex;
        logic [SIG_W:0]   rem;
        logic [SIG_W-1:0] dvs;
        logic [QW-1:0]    quo;
    } st_t;

    st_t st_d, st_q;
    logic [SIG_W:0]   r_w;
    logic [SIG_W+1:0] t_w;
    logic [QW-1:0]    q_w;

    always_comb begin
        st_d     = st_q;
        up_ready = !st_q.vld || dn_ready;
        r_w      = up_rem;
        q_w      = up_quo;
        t_w      = '0;
        for (int k = 0; k < BITS_PER; k++) begin
            if (ABS_BASE + k < QW) begin
                // absolute step 0 compares the dividend itself, later steps shift in a zero
                if (ABS_BASE + k == 0) t_w = {1'b0, r_w};
                else                   t_w = {r_w, 1'b0};
                if (t_w >= {2'b00, up_dvs}) begin
                    t_w = t_w - {2'b00, up_dvs};
                    q_w[QW-1-((ABS_BASE+k) % QW)] = 1'b1;
                end
                r_w = t_w[SIG_W:0];
            end
        end
        if (up_ready) begin
            st_d.vld = up_valid;
            if (up_valid) begin
                st_d.flg = up_flag;
                st_d.ex  = up_exp;
                st_d.rem = r_w;
                st_d.dvs = up_dvs;
                st_d.quo = q_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dn_valid = st_q.vld;
    assign dn_flag  = st_q.flg;
    assign dn_exp   = st_q.ex;
    assign dn_rem   = st_q.rem;
    assign dn_dvs   = st_q.dvs;
    assign dn_quo   = st_q.quo;

    AST_REM_BELOW_DVS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_rem < {1'b0, dn_dvs}); // R3

    AST_PENDING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (dn_quo & PEND_MASK) == '0); // R1

    AST_CALC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_quo) && $stable(dn_rem) && $stable(dn_flag)); // R8

endmodule

// File: rtl/fdiv_final.sv
module fdiv_final
    import fdiv_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W,
    parameter int RX_W  = DEF_EXP_W + 2,
    parameter int QW    = quo_width(SIG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    output logic             up_ready,
    input  fdiv_flag_t       up_flag,
    input  logic [RX_W-1:0]  up_exp,
    input  logic [SIG_W:0]   up_rem,
    input  logic [SIG_W-1:0] up_dvs,
    input  logic [QW-1:0]    up_quo,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sgn,
    output logic [RX_W-1:0]  out_exp,
    output logic [SIG_W-1:0] out_mant,
    output logic             out_lsb,
    output logic             out_guard,
    output logic             out_round,
    output logic             out_sticky,
    output logic             out_bypass
);

    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic             byp;
        logic [RX_W-1:0]  ex;
        logic [SIG_W-1:0] mant;
        logic             lsb;
        logic             grd;
        logic             rnd;
        logic             stk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        up_ready = !st_q.vld || out_ready;
        if (up_ready) begin
            st_d.vld = up_valid;
            if (up_valid) begin
                st_d.sgn  = up_flag.sgn;
                st_d.byp  = up_flag.byp;
                st_d.ex   = up_exp;
                st_d.mant = '0;
                st_d.lsb  = 1'b0;
                st_d.grd  = 1'b0;
                st_d.rnd  = 1'b0;
                st_d.stk  = 1'b0;
                if (!up_flag.byp) begin
                    st_d.mant = up_quo[QW-1:SIG_W+2];
                    st_d.lsb  = up_quo[SIG_W+2];
                    st_d.grd  = up_quo[SIG_W+1];
                    st_d.rnd  = up_quo[SIG_W];
                    st_d.stk  = (|up_quo[SIG_W-1:0]) | (|up_rem);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_sgn    = st_q.sgn;
    assign out_bypass = st_q.byp;
    assign out_exp    = st_q.ex;
    assign out_mant   = st_q.mant;
    assign out_lsb    = st_q.lsb;
    assign out_guard  = st_q.grd;
    assign out_round  = st_q.rnd;
    assign out_sticky = st_q.stk;

    AST_FINAL_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |-> up_rem < {1'b0, up_dvs}); // R3

    AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_bypass |-> out_mant[SIG_W-1:SIG_W-2] != 2'b00); // R6

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bypass |-> {out_mant, out_lsb, out_guard, out_round, out_sticky} == '0); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
                                 && $stable(out_sticky) && $stable(out_sgn)); // R8

endmodule

// File: rtl/fdiv_sig_pipe.sv
module fdiv_sig_pipe
    import fdiv_pkg::*;
#(
    parameter int SIG_W    = DEF_SIG_W,
    parameter int EXP_W    = DEF_EXP_W,
    parameter int BITS_PER = DEF_BITS_PER
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sgn_a,
    input  logic [EXP_W-1:0]   in_exp_a,
    input  logic [SIG_W-1:0]   in_sig_a,
    input  logic               in_sgn_b,
    input  logic [EXP_W-1:0]   in_exp_b,
    input  logic [SIG_W-1:0]   in_sig_b,
    input  logic               in_bypass,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_sgn,
    output logic [EXP_W+1:0]   out_exp,
    output logic [SIG_W-1:0]   out_mant,
    output logic               out_lsb,
    output logic               out_guard,
    output logic               out_round,
    output logic               out_sticky,
    output logic               out_bypass
);

    localparam int QW       = quo_width(SIG_W);
    localparam int RX_W     = EXP_W + 2;
    localparam int NUM_CALC = (QW + BITS_PER - 1) / BITS_PER;

    // link 0 is the setup stage output, link g+1 the output of calculate stage g
    logic             lv [0:NUM_CALC];
    logic             lr [0:NUM_CALC];
    fdiv_flag_t       lf [0:NUM_CALC];
    logic [RX_W-1:0]  lx [0:NUM_CALC];
    logic [SIG_W:0]   lm [0:NUM_CALC];
    logic [SIG_W-1:0] ld [0:NUM_CALC];
    logic [QW-1:0]    lq [0:NUM_CALC];

    fdiv_setup #(.SIG_W(SIG_W), .EXP_W(EXP_W), .QW(QW), .RX_W(RX_W)) u_setup (
        .clk(clk), .rst_n(rst_n),
        .up_valid(in_valid), .up_ready(in_ready),
        .a_sgn(in_sgn_a), .a_exp(in_exp_a), .a_sig(in_sig_a),
        .b_sgn(in_sgn_b), .b_exp(in_exp_b), .b_sig(in_sig_b),
        .byp(in_bypass),
        .dn_valid(lv[0]), .dn_ready(lr[0]), .dn_flag(lf[0]), .dn_exp(lx[0]),
        .dn_rem(lm[0]), .dn_dvs(ld[0]), .dn_quo(lq[0])
    );

    for (genvar g = 0; g < NUM_CALC; g++) begin : g_calc
        fdiv_calc #(
            .SIG_W(SIG_W), .RX_W(RX_W), .QW(QW),
            .BITS_PER(BITS_PER), .ABS_BASE(g * BITS_PER)
        ) u_calc (
            .clk(clk), .rst_n(rst_n),
            .up_valid(lv[g]), .up_ready(lr[g]), .up_flag(lf[g]), .up_exp(lx[g]),
            .up_rem(lm[g]), .up_dvs(ld[g]), .up_quo(lq[g]),
            .dn_valid(lv[g+1]), .dn_ready(lr[g+1]), .dn_flag(lf[g+1]), .dn_exp(lx[g+1]),
            .dn_rem(lm[g+1]), .dn_dvs(ld[g+1]), .dn_quo(lq[g+1])
        );
    end

    fdiv_final #(.SIG_W(SIG_W), .RX_W(RX_W), .QW(QW)) u_final (
        .clk(clk), .rst_n(rst_n),
        .up_valid(lv[NUM_CALC]), .up_ready(lr[NUM_CALC]), .up_flag(lf[NUM_CALC]),
        .up_exp(lx[NUM_CALC]), .up_rem(lm[NUM_CALC]), .up_dvs(ld[NUM_CALC]),
        .up_quo(lq[NUM_CALC]),
        .out_valid(out_valid), .out_ready(out_ready), .out_sgn(out_sgn),
        .out_exp(out_exp), .out_mant(out_mant), .out_lsb(out_lsb),
        .out_guard(out_guard), .out_round(out_round), .out_sticky(out_sticky),
        .out_bypass(out_bypass)
    );

    AST_READY_WHEN_FLOWING: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R10

endmodule

// File: tb/fdiv_sig_pipe_tb.sv
module fdiv_sig_pipe_tb;

    localparam int SIG_W    = 8;
    localparam int EXP_W    = 10;
    localparam int QW       = 2 * SIG_W + 2;
    localparam int RX_W     = EXP_W + 2;
    localparam int NUM_CALC = 6;
    localparam int N_OPS    = 500;

    typedef struct {
        bit               s;
        logic [RX_W-1:0]  e;
        logic [SIG_W-1:0] m;
        bit l, g, r, k, b;
    } res_t;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_sgn_a, in_sgn_b, in_bypass;
    logic [EXP_W-1:0] in_exp_a, in_exp_b;
    logic [SIG_W-1:0] in_sig_a, in_sig_b;
    logic out_valid, out_ready, out_sgn, out_lsb, out_guard, out_round, out_sticky, out_bypass;
    logic [RX_W-1:0]  out_exp;
    logic [SIG_W-1:0] out_mant;

    int total = 0;
    int bad   = 0;
    res_t sb[$];

    always #10 clk = ~clk;

    fdiv_sig_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sgn_a(in_sgn_a), .in_exp_a(in_exp_a), .in_sig_a(in_sig_a),
        .in_sgn_b(in_sgn_b), .in_exp_b(in_exp_b), .in_sig_b(in_sig_b),
        .in_bypass(in_bypass), .out_valid(out_valid), .out_ready(out_ready),
        .out_sgn(out_sgn), .out_exp(out_exp), .out_mant(out_mant), .out_lsb(out_lsb),
        .out_guard(out_guard), .out_round(out_round), .out_sticky(out_sticky),
        .out_bypass(out_bypass)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic res_t model();
        res_t o;
        longint unsigned num, q, rm;
        int d;
        num = longint'(in_sig_a) << (QW - 1);
        q   = num / longint'(in_sig_b);
        rm  = num % longint'(in_sig_b);
        d   = int'($signed(in_exp_a)) - int'($signed(in_exp_b)) + 1;
        o.s = in_sgn_a ^ in_sgn_b;
        o.e = d[RX_W-1:0];
        o.b = in_bypass;
        o.m = '0; o.l = 0; o.g = 0; o.r = 0; o.k = 0;
        if (!in_bypass) begin
            o.m = q[QW-1:SIG_W+2];
            o.l = q[SIG_W+2];
            o.g = q[SIG_W+1];
            o.r = q[SIG_W];
            o.k = (q[SIG_W-1:0] != 0) || (rm != 0);
        end
        return o;
    endfunction

    task automatic set_op(input int idx);
        in_sgn_a  = 1'($urandom);
        in_sgn_b  = 1'($urandom);
        in_exp_a  = EXP_W'($urandom);
        in_exp_b  = EXP_W'($urandom);
        in_sig_a  = SIG_W'($urandom) | 8'h80;
        in_sig_b  = SIG_W'($urandom) | 8'h80;
        in_bypass = ($urandom % 12) == 0;
        case (idx)
            0: begin in_sig_a = 8'hFF; in_sig_b = 8'h80; in_bypass = 0; end
            1: begin in_sig_a = 8'h80; in_sig_b = 8'hFF; in_bypass = 0; end
            2: begin in_sig_a = 8'h80; in_sig_b = 8'h80; in_bypass = 0; end
            3: begin in_sig_a = 8'hFF; in_sig_b = 8'hFF; in_bypass = 0; end
            4: begin in_exp_a = 10'h1FF; in_exp_b = 10'h200; in_bypass = 0; end
            5: begin in_exp_a = 10'h200; in_exp_b = 10'h1FF; in_bypass = 0; end
            6: begin in_bypass = 1; end
            7: begin in_sig_a = 8'hC3; in_sig_b = 8'hC3; in_sgn_a = 1; in_sgn_b = 1; in_bypass = 0; end
            default: ;
        endcase
    endtask

    task automatic cmp_out(input res_t e);
        chk(out_sgn == e.s, "R5", "sign", out_sgn, e.s);
        chk(out_exp == e.e, "R4", "exp", out_exp, e.e);
        chk(out_mant == e.m, "R1", "mant", out_mant, e.m);
        chk({out_lsb, out_guard, out_round} == {e.l, e.g, e.r}, "R2", "lsb/guard/round",
            {out_lsb, out_guard, out_round}, {e.l, e.g, e.r});
        chk(out_sticky == e.k, "R3", "sticky", out_sticky, e.k);
        chk(out_bypass == e.b, "R7", "bypass", out_bypass, e.b);
        if (!e.b) chk(out_mant[SIG_W-1:SIG_W-2] != 2'b00, "R6", "mant top", out_mant, e.m);
    endtask

    initial begin
        int issued, lat, cyc, got, stall_miss;
        bit acc, take, stall_prev, timeout;
        logic [RX_W+SIG_W+6:0] snap;
        res_t e;
        void'($urandom(32'd2024));
        rst_n = 0; in_valid = 0; out_ready = 0;
        set_op(8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1, "R11", "in_ready in reset", in_ready, 1);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R11", "after reset", {out_valid, in_ready}, 2'b01);

        // R10 latency with a single directed operation (all-ones over MSB-only)
        @(posedge clk); #1;
        set_op(0); in_valid = 1; out_ready = 1;
        e = model();
        @(posedge clk); #1 in_valid = 0;
        lat = 1;
        @(negedge clk);
        while (!out_valid && lat < 40) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        chk(lat == NUM_CALC + 2, "R10", "latency", lat, NUM_CALC + 2);
        cmp_out(e);
        @(posedge clk); #1;

        // streaming: directed extremes first, then random with back-pressure
        issued = 1; got = 0; cyc = 0; stall_prev = 0; timeout = 0; stall_miss = 0;
        set_op(issued); in_valid = 1;
        while ((issued < N_OPS || sb.size() != 0) && !timeout) begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) timeout = 1;
            if (stall_prev)
                chk(out_valid && snap == {out_exp, out_mant, out_sgn, out_lsb, out_guard,
                    out_round, out_sticky, out_bypass}, "R8", "held output",
                    {out_exp, out_mant}, snap[RX_W+SIG_W+6:6]);
            if (issued >= 8 && issued < 60 && in_valid && !in_ready) stall_miss++;
            acc  = in_valid && in_ready;
            take = out_valid && out_ready;
            if (take) begin
                if (sb.size() == 0) chk(0, "R9", "unexpected result", 1, 0);
                else begin e = sb.pop_front(); cmp_out(e); got++; end
            end
            stall_prev = out_valid && !out_ready;
            snap = {out_exp, out_mant, out_sgn, out_lsb, out_guard, out_round, out_sticky, out_bypass};
            @(posedge clk); #1;
            if (acc) begin
                sb.push_back(model());
                issued++;
                if (issued < N_OPS) set_op(issued);
            end
            if (issued < 60) begin
                // full-throughput window (R10): inputs always offered, output always taken
                in_valid = issued < N_OPS; out_ready = 1;
            end else begin
                in_valid  = (issued < N_OPS) && (($urandom % 4) != 0);
                out_ready = ($urandom % 3) != 0;
                if ((cyc % 200) < 25) out_ready = 0;
            end
        end
        chk(!timeout, "R9", "watchdog", cyc, 150000);
        chk(stall_miss == 0, "R10", "in_ready at full rate", stall_miss, 0);
        chk(got == N_OPS - 1 && sb.size() == 0, "R9", "result count", got, N_OPS - 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule